// File: doc/BRIEF.md
# Multicycle Instruction Sequencer and Decoder

This block is the control unit of a small 8-bit processor with 16-bit instructions and a 15-bit byte address space. It fetches each instruction as two bytes over an 8-bit read bus, high byte first. It decodes register, register-immediate and jump formats, then steps through a fixed number of clock cycles for that instruction. The register file, ALU and flag register sit outside the block. The block drives their selects, operation code and write strobes, and it takes back the current destination-register value, the pointer register pair and the flag byte.

The block owns the program counter and a stack pointer. The program counter starts at 0. The stack pointer starts at the top of the address space and grows downward. Loads and stores use an address made from a register pair. Register pushes, flag pushes, subroutine calls and returns all move data through the stack one byte at a time. Memory reads are combinational: the returned byte is valid in the same cycle as the address. A write takes effect at the clock edge that ends a cycle in which the write strobe is high.

Top module: `seq_core`

## Requirements
- R1: After a synchronous active-low reset, the PC is 0, the stack pointer is 0x7FFF, the block is in its first fetch cycle (`instr_start` high) and `mem_we` is low.
- R2: Each instruction is fetched from `pc` (upper byte, bits [15:12] = major opcode) and `pc+1` (lower byte) in its first two cycles, and the next instruction starts at `pc+2` unless a jump, call or return redirects it.
- R3: Instruction length in cycles: 3 for register ALU ops, register-immediate ops, compares, and relative or conditional jumps; 4 for LD (function 6), ST (7), PUSH (8), PUSHF (10) and POPF (11); 5 for POP (9); 6 for RCALL (opcode 10); 7 for RET (opcode 9).
- R4: Register-format ops (opcode 0) select Rd from bits [11:8] and Rr from bits [7:4], and pass function bits [3:0] as `alu_op`. Immediate ops (opcodes 1..7) assert `alu_use_imm` with `imm` = bits [7:0], and map to `alu_op` 15,1,2,3,4,5,0 in opcode order. Compares (function 15, opcode 1) raise `flag_we` but never `rf_we`.
- R5: LD and ST address memory at {`ptr_hi`[6:0], `ptr_lo`}. LD writes Rd from `mem_rdata` (`rf_from_mem` high), and ST writes `rd_val`.
- R6: PUSH and PUSHF write at the stack pointer and then decrement it. POP and POPF first increment it and then read there. POPF asserts `flag_load`.
- R7: Conditional jumps (opcodes 11..15 = JE, JNE, JB, JAE, JL) test flag bits Z=`flags`[0], C=`flags`[1] and L=`flags`[2]. A false condition falls through to `pc+2` and still takes 3 cycles.
- R8: A taken jump or call goes to `pc+2` plus the sign-extended 12-bit offset in bits [11:0], modulo 2^15. The PC holds its value until the instruction's last cycle.
- R9: RCALL stores the return address `pc+2` as two bytes, high byte first, at descending stack addresses. RET reads the low byte and then the high byte and resumes there.
- R10: `mem_we` is asserted only in cycles after the fetch and first execute cycle, and only by ST, PUSH, PUSHF and RCALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| mem_addr | output | 15 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Memory write strobe |
| rd_sel | output | 4 | Destination register select |
| rr_sel | output | 4 | Source register select |
| rd_val | input | 8 | Contents of the selected destination register |
| ptr_lo | input | 8 | Low pointer register contents |
| ptr_hi | input | 8 | High pointer register contents |
| flags | input | 8 | Flag byte: bit0 Z, bit1 C, bit2 L |
| alu_op | output | 4 | ALU operation code |
| alu_use_imm | output | 1 | ALU second operand is `imm` |
| imm | output | 8 | Immediate operand |
| rf_we | output | 1 | Register file write strobe |
| rf_from_mem | output | 1 | Register write data comes from `mem_rdata` |
| flag_we | output | 1 | Flags update from ALU |
| flag_load | output | 1 | Flags load from `mem_rdata` |
| pc | output | 15 | Address of the current instruction |
| instr_start | output | 1 | First fetch cycle of an instruction |

## Verification
The embedded properties check the following on every cycle:
- the step counter stays inside the current instruction's length;
- writes happen only in late execute cycles;
- the PC and stack pointer stay unchanged except when their update is due;
- compares never write a register.

Some behaviour can only be shown by the directed program the bench runs:
- exact cycle counts per instruction;
- jump targets, including a negative offset;
- fall-through of a false condition;
- the byte order of the return address on the stack;
- the round trip of flags through memory.

// File: rtl/seq_pkg.sv
// Shared types for the sequencer: instruction classes and their lengths.
// Assumes a step counter of STEP_W bits is wide enough for the longest class.
package seq_pkg;
    localparam int STEP_W = 3;
    localparam int FLG_Z  = 0;
    localparam int FLG_C  = 1;
    localparam int FLG_L  = 2;

    typedef enum logic [3:0] {
        CL_ALU, CL_LD, CL_ST, CL_PUSH, CL_POP,
        CL_PUSHF, CL_POPF, CL_JMP, CL_CALL, CL_RET
    } cls_e;

    // Fixed cycle count for each instruction class.
    function automatic logic [STEP_W-1:0] cls_len(cls_e c);
        case (c)
            CL_LD, CL_ST, CL_PUSH, CL_PUSHF, CL_POPF: cls_len = STEP_W'(4);
            CL_POP:  cls_len = STEP_W'(5);
            CL_CALL: cls_len = STEP_W'(6);
            CL_RET:  cls_len = STEP_W'(7);
            default: cls_len = STEP_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/seq_decode.sv
// Instruction decoder: classifies a 16-bit word, gives its length, ALU
// controls and the jump decision. Purely combinational.
// Assumes a 4-bit major opcode at the top and a 4-bit function at the bottom.
module seq_decode
    import seq_pkg::*;
#(
    parameter int IW = 16,
    parameter int DW = 8
) (
    input  logic [IW-1:0]     ir,
    input  logic [DW-1:0]     flags,
    output cls_e              cls,
    output logic [STEP_W-1:0] len,
    output logic [3:0]        alu_op,
    output logic              use_imm,
    output logic              writes_rd,
    output logic              sets_flags,
    output logic              taken
);
    logic [3:0] opc;
    logic [3:0] fn;
    assign opc = ir[IW-1 -: 4];
    assign fn  = ir[3:0];

    // Map opcode and function to class and control bits.
    always_comb begin
        cls        = CL_ALU;
        alu_op     = fn;
        use_imm    = 1'b0;
        writes_rd  = 1'b0;
        sets_flags = 1'b0;
        taken      = 1'b0;
        case (opc)
            4'h0: begin
                case (fn)
                    4'h6: cls = CL_LD;
                    4'h7: cls = CL_ST;
                    4'h8: cls = CL_PUSH;
                    4'h9: cls = CL_POP;
                    4'hA: cls = CL_PUSHF;
                    4'hB: cls = CL_POPF;
                    4'hF: sets_flags = 1'b1;
                    default: begin
                        writes_rd  = 1'b1;
                        sets_flags = (fn != 4'h0);
                    end
                endcase
            end
            4'h1: begin
                use_imm    = 1'b1;
                alu_op     = 4'hF;
                sets_flags = 1'b1;
            end
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6: begin
                use_imm    = 1'b1;
                alu_op     = opc - 4'h1;
                writes_rd  = 1'b1;
                sets_flags = 1'b1;
            end
            4'h7: begin
                use_imm   = 1'b1;
                alu_op    = 4'h0;
                writes_rd = 1'b1;
            end
            4'h8: begin cls = CL_JMP; taken = 1'b1; end
            4'h9: cls = CL_RET;
            4'hA: cls = CL_CALL;
            4'hB: begin cls = CL_JMP; taken = flags[FLG_Z]; end
            4'hC: begin cls = CL_JMP; taken = !flags[FLG_Z]; end
            4'hD: begin cls = CL_JMP; taken = flags[FLG_C]; end
            4'hE: begin cls = CL_JMP; taken = !flags[FLG_C]; end
            default: begin cls = CL_JMP; taken = flags[FLG_L]; end
        endcase
    end

    assign len = cls_len(cls);
endmodule

// File: rtl/seq_stack.sv
// Stack pointer: resets to the top of the address space, moves by one byte
// on request. Assumes inc and dec are never both high.
module seq_stack #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp
);
    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= '1;
        else if (inc) sp <= sp + AW'(1);
        else if (dec) sp <= sp - AW'(1);
    end

    p_sp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(sp));
    p_sp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
endmodule

// File: rtl/seq_pcu.sv
// Program counter with sequential and relative next-address outputs.
// Assumes OW < AW; the offset is two's complement in bytes from pc+2.
module seq_pcu #(
    parameter int AW = 15,
    parameter int OW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pc_seq,
    output logic [AW-1:0] pc_rel
);
    localparam int EXT = AW - OW;

    assign pc_seq = pc + AW'(2);
    assign pc_rel = pc_seq + {{EXT{offset[OW-1]}}, offset};

    // PC register, loaded once per instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (load) pc <= load_val;
    end

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pc));
endmodule

// File: rtl/seq_core.sv
// Control unit top: two-byte fetch, decode, fixed-length step sequencing,
// stack and memory requests. Assumes combinational memory reads and an
// external register file and ALU that act on the strobes driven here.
module seq_core
    import seq_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8,
    parameter int IW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [RW-1:0] rd_sel,
    output logic [RW-1:0] rr_sel,
    input  logic [DW-1:0] rd_val,
    input  logic [DW-1:0] ptr_lo,
    input  logic [DW-1:0] ptr_hi,
    input  logic [DW-1:0] flags,
    output logic [3:0]    alu_op,
    output logic          alu_use_imm,
    output logic [DW-1:0] imm,
    output logic          rf_we,
    output logic          rf_from_mem,
    output logic          flag_we,
    output logic          flag_load,
    output logic [AW-1:0] pc,
    output logic          instr_start
);
    localparam int OW  = IW - 4;
    localparam int HIW = AW - DW;

    logic [STEP_W-1:0] step_q;
    logic [DW-1:0]     ir_hi, ir_lo, ret_lo, ret_hi;
    logic [IW-1:0]     ir;
    cls_e              cls;
    logic [STEP_W-1:0] len;
    logic              use_imm, writes_rd, sets_flags, taken;
    logic [AW-1:0]     sp, pc_seq, pc_rel, pc_next;
    logic              last, sp_inc, sp_dec;

    assign ir          = {ir_hi, ir_lo};
    assign rd_sel      = ir[11:8];
    assign rr_sel      = ir[7:4];
    assign imm         = ir[7:0];
    assign alu_use_imm = use_imm;
    assign instr_start = (step_q == '0);
    assign last        = (step_q >= STEP_W'(2)) && (step_q == len - STEP_W'(1));

    seq_decode #(.IW(IW), .DW(DW)) u_dec (
        .ir(ir), .flags(flags), .cls(cls), .len(len), .alu_op(alu_op),
        .use_imm(use_imm), .writes_rd(writes_rd), .sets_flags(sets_flags),
        .taken(taken)
    );

    seq_stack #(.AW(AW)) u_stk (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp)
    );

    seq_pcu #(.AW(AW), .OW(OW)) u_pcu (
        .clk(clk), .rst_n(rst_n), .load(last), .load_val(pc_next),
        .offset(ir[OW-1:0]), .pc(pc), .pc_seq(pc_seq), .pc_rel(pc_rel)
    );

    // Step counter: wraps to fetch after the instruction's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= '0;
        else if (last) step_q <= '0;
        else           step_q <= step_q + STEP_W'(1);
    end

    // Instruction and return-address byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_hi  <= '0;
            ir_lo  <= '0;
            ret_lo <= '0;
            ret_hi <= '0;
        end else begin
            if (step_q == STEP_W'(0)) ir_hi <= mem_rdata;
            if (step_q == STEP_W'(1)) ir_lo <= mem_rdata;
            if (cls == CL_RET && step_q == STEP_W'(4)) ret_lo <= mem_rdata;
            if (cls == CL_RET && step_q == STEP_W'(5)) ret_hi <= mem_rdata;
        end
    end

    // Next PC chosen at the last step.
    always_comb begin
        pc_next = pc_seq;
        if ((cls == CL_JMP && taken) || cls == CL_CALL) pc_next = pc_rel;
        else if (cls == CL_RET) pc_next = {ret_hi[HIW-1:0], ret_lo};
    end

    // Per-step bus, register file and stack actions.
    always_comb begin
        mem_addr    = pc;
        mem_wdata   = rd_val;
        mem_we      = 1'b0;
        rf_we       = 1'b0;
        rf_from_mem = 1'b0;
        flag_we     = 1'b0;
        flag_load   = 1'b0;
        sp_inc      = 1'b0;
        sp_dec      = 1'b0;
        if (step_q == STEP_W'(1)) mem_addr = pc + AW'(1);
        case (cls)
            CL_ALU: if (step_q == STEP_W'(2)) begin
                rf_we   = writes_rd;
                flag_we = sets_flags;
            end
            CL_LD: if (step_q == STEP_W'(3)) begin
                mem_addr    = {ptr_hi[HIW-1:0], ptr_lo};
                rf_we       = 1'b1;
                rf_from_mem = 1'b1;
            end
            CL_ST: if (step_q == STEP_W'(3)) begin
                mem_addr = {ptr_hi[HIW-1:0], ptr_lo};
                mem_we   = 1'b1;
            end
            CL_PUSH, CL_PUSHF: if (step_q == STEP_W'(3)) begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = (cls == CL_PUSHF) ? flags : rd_val;
                sp_dec    = 1'b1;
            end
            CL_POP: begin
                if (step_q == STEP_W'(2)) sp_inc = 1'b1;
                if (step_q == STEP_W'(4)) begin
                    mem_addr    = sp;
                    rf_we       = 1'b1;
                    rf_from_mem = 1'b1;
                end
            end
            CL_POPF: begin
                if (step_q == STEP_W'(2)) sp_inc = 1'b1;
                if (step_q == STEP_W'(3)) begin
                    mem_addr  = sp;
                    flag_load = 1'b1;
                end
            end
            CL_CALL: if (step_q == STEP_W'(3) || step_q == STEP_W'(4)) begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                sp_dec    = 1'b1;
                mem_wdata = (step_q == STEP_W'(3)) ? DW'(pc_seq[AW-1:DW])
                                                   : pc_seq[DW-1:0];
            end
            CL_RET: begin
                if (step_q == STEP_W'(3) || step_q == STEP_W'(4)) sp_inc = 1'b1;
                if (step_q == STEP_W'(4) || step_q == STEP_W'(5)) mem_addr = sp;
            end
            default: ;
        endcase
    end

    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q >= STEP_W'(2)) |-> (step_q < len));
    p_we_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (step_q >= STEP_W'(3)));
    p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !(ir[IW-1 -: 4] == 4'h1 || (ir[IW-1 -: 4] == 4'h0 && ir[3:0] == 4'hF)));
    p_fetch_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_W'(1)) |=> (step_q == STEP_W'(2)) && $stable(pc));
endmodule

// File: tb/sim_seq_core.sv
`timescale 1ns/1ps
module sim_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata, mem_wdata, rd_val, ptr_lo, ptr_hi, imm;
    logic [14:0] mem_addr, pc;
    logic        mem_we, alu_use_imm, rf_we, rf_from_mem, flag_we, flag_load;
    logic        instr_start;
    logic [3:0]  rd_sel, rr_sel, alu_op;
    logic [7:0]  mem [1024];
    logic [7:0]  regs [16];
    logic [7:0]  flags_q;
    int          n_chk = 0, n_bad = 0;
    int          we_cnt = 0, rfw_cnt = 0, flw_cnt = 0;
    logic [14:0] last_we_addr;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    seq_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .rd_sel(rd_sel), .rr_sel(rr_sel),
        .rd_val(rd_val), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .flags(flags_q),
        .alu_op(alu_op), .alu_use_imm(alu_use_imm), .imm(imm), .rf_we(rf_we),
        .rf_from_mem(rf_from_mem), .flag_we(flag_we), .flag_load(flag_load),
        .pc(pc), .instr_start(instr_start)
    );

    assign mem_rdata = mem[mem_addr[9:0]];
    assign rd_val    = regs[rd_sel];
    assign ptr_lo    = regs[14];
    assign ptr_hi    = regs[15];

    // Memory, register file (load-immediate only) and flags models.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                last_we_addr <= mem_addr;
                we_cnt <= we_cnt + 1;
            end
            if (rf_we) begin
                rfw_cnt <= rfw_cnt + 1;
                if (rf_from_mem) regs[rd_sel] <= mem_rdata;
                else if (alu_use_imm && alu_op == 4'h0) regs[rd_sel] <= imm;
            end
            if (flag_we) flw_cnt <= flw_cnt + 1;
            if (flag_load) flags_q <= mem_rdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Runs one instruction from its first fetch; checks length and next PC.
    task automatic exec(input int exp_len, input logic [14:0] exp_pc, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!instr_start && n < 20);
        chk(n == exp_len, {tag, " R3 length"}, n, exp_len);
        chk(pc == exp_pc, {tag, " next pc"}, pc, exp_pc);
    endtask

    task automatic put16(input int a, input logic [15:0] w);
        mem[a]   = w[15:8];
        mem[a+1] = w[7:0];
    endtask

    task automatic t_reset;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) regs[i] = 8'h00;
        flags_q = 8'h00;
        put16(12'h000, 16'h715A); put16(12'h002, 16'h7E20);
        put16(12'h004, 16'h7F03); put16(12'h006, 16'h0107);
        put16(12'h008, 16'h0206); put16(12'h00A, 16'h0108);
        put16(12'h00C, 16'h0309); put16(12'h00E, 16'h000A);
        put16(12'h010, 16'h000B); put16(12'h012, 16'hB002);
        put16(12'h016, 16'hD002); put16(12'h018, 16'hA010);
        put16(12'h01A, 16'h012F); put16(12'h01C, 16'h8FFE);
        put16(12'h02A, 16'h9DD0);
        repeat (3) @(negedge clk);
        chk(pc == 15'h0, "R1 pc in reset", pc, 0);
        chk(mem_we == 1'b0, "R1 no write in reset", mem_we, 0);
        rst_n = 1'b1;
        chk(instr_start == 1'b1, "R1 fetch step after reset", instr_start, 1);
        chk(mem_addr == 15'h0, "R2 first fetch address", mem_addr, 0);
    endtask

    task automatic t_immediates;
        exec(3, 15'h002, "MOVI R1");
        chk(regs[1] == 8'h5A, "R4 immediate into R1", regs[1], 8'h5A);
        chk(flw_cnt == 0, "R4 load-immediate leaves flags", flw_cnt, 0);
        exec(3, 15'h004, "MOVI R14");
        exec(3, 15'h006, "MOVI R15");
        chk(regs[14] == 8'h20 && regs[15] == 8'h03, "R4 pointer pair", {regs[15], regs[14]}, 16'h0320);
    endtask

    task automatic t_load_store;
        int w0 = we_cnt;
        exec(4, 15'h008, "ST");
        chk(we_cnt - w0 == 1, "R10 one write by ST", we_cnt - w0, 1);
        chk(last_we_addr == 15'h0320, "R5 ST address", last_we_addr, 15'h0320);
        chk(mem[10'h320] == 8'h5A, "R5 ST data", mem[10'h320], 8'h5A);
        w0 = we_cnt;
        exec(4, 15'h00A, "LD");
        chk(regs[2] == 8'h5A, "R5 LD data", regs[2], 8'h5A);
        chk(we_cnt == w0, "R10 LD does not write", we_cnt - w0, 0);
    endtask

    task automatic t_stack_regs;
        exec(4, 15'h00C, "PUSH");
        chk(last_we_addr == 15'h7FFF, "R6 first push at top", last_we_addr, 15'h7FFF);
        chk(mem[10'h3FF] == 8'h5A, "R6 pushed byte", mem[10'h3FF], 8'h5A);
        exec(5, 15'h00E, "POP");
        chk(regs[3] == 8'h5A, "R6 popped byte", regs[3], 8'h5A);
    endtask

    task automatic t_stack_flags;
        flags_q = 8'h05;
        exec(4, 15'h010, "PUSHF");
        chk(last_we_addr == 15'h7FFF, "R6 flags pushed at restored top", last_we_addr, 15'h7FFF);
        chk(mem[10'h3FF] == 8'h05, "R6 pushed flags", mem[10'h3FF], 8'h05);
        flags_q = 8'h00;
        exec(4, 15'h012, "POPF");
        chk(flags_q == 8'h05, "R6 flags restored", flags_q, 8'h05);
    endtask

    task automatic t_cond_jumps;
        exec(3, 15'h016, "JE taken R7");
        exec(3, 15'h018, "JB not taken R7");
    endtask

    task automatic t_call_return;
        int w0 = we_cnt;
        exec(6, 15'h02A, "RCALL R8");
        chk(we_cnt - w0 == 2, "R9 two bytes pushed", we_cnt - w0, 2);
        chk(mem[10'h3FF] == 8'h00, "R9 high byte first", mem[10'h3FF], 8'h00);
        chk(mem[10'h3FE] == 8'h1A, "R9 low byte below", mem[10'h3FE], 8'h1A);
        exec(7, 15'h01A, "RET R9");
    endtask

    task automatic t_compare_loop;
        int r0 = rfw_cnt, f0 = flw_cnt;
        exec(3, 15'h01C, "CMP");
        chk(rfw_cnt == r0, "R4 compare writes no register", rfw_cnt - r0, 0);
        chk(flw_cnt - f0 == 1, "R4 compare updates flags", flw_cnt - f0, 1);
        chk(regs[1] == 8'h5A, "R4 compare leaves Rd", regs[1], 8'h5A);
        exec(3, 15'h01C, "RJMP back R8");
        exec(3, 15'h01C, "RJMP again R2");
    endtask

    initial begin
        t_reset();
        t_immediates();
        t_load_store();
        t_stack_regs();
        t_stack_flags();
        t_cond_jumps();
        t_call_return();
        t_compare_loop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule